// File: doc/BRIEF.md
# Page-Mode Static Memory Model

A clocked, synthesizable model of a 16-bit word memory with the control scheme of a low-power asynchronous static RAM. An access is decoded every clock from two chip selects of opposite polarity, an active-low write strobe, an active-low output gate and two active-low byte-lane selects. Writes land in the enabled byte lanes at the clock edge. Reads hand back data after a latency counted in clocks. The latency is short when the new word sits in the same 16-word page as the last read that completed, and long otherwise.

The tri-state data bus is split into an input bus, an output bus and a per-lane drive flag. A lane whose flag is low reads as zero. Depth, page size and both latencies are parameters. The defaults are 1024 words, 16-word pages, a 3-clock random read and a 1-clock page read.

Top module: `paged_sram`

## Requirements
- R1: When `selLowN` is 1 or `selHigh` is 0, the chip is in standby. At the next edge `outValid` is 2'b00 and no memory word changes, whatever the other inputs are.
- R2: When `hiByteN` and `loByteN` are both 1, the chip is also in standby. Outputs are undriven at the next edge and a low `wrN` writes nothing.
- R3: With the chip selected, a byte-lane select low and `wrN` low, `dataIn[7:0]` is stored when `loByteN` is 0 and `dataIn[15:8]` is stored when `hiByteN` is 0. Disabled lanes keep their contents. `oeN` has no effect, and `outValid` is 2'b00 after the write edge.
- R4: On a read, `outValid[0]` and `dataOut[7:0]` follow `loByteN`, and `outValid[1]` and `dataOut[15:8]` follow `hiByteN`. The data byte of an undriven lane is zero.
- R5: A read whose page (address bits above bit 3) differs from the page of the last completed read, or that follows standby, becomes valid after its third clock edge of held address. It is invalid after the first and second edges.
- R6: A read to the same page as the last completed read, with no standby since, becomes valid after its first edge. Writes in between do not break this page-hit state.
- R7: Any standby cycle clears the page-hit state, so the next read takes the random latency of R5.
- R8: A read whose address changes, or that is interrupted by standby, before its latency elapses presents no data. The new address starts a fresh count.
- R9: With `oeN` at 1 during a selected read, outputs stay undriven but the access keeps counting. Once the latency has elapsed, dropping `oeN` drives the data after one edge.
- R10: During and right after reset, `outValid` is 2'b00 and `dataOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Word address; bits 3..0 pick the word inside a page |
| selLowN | input | 1 | Chip select, active low |
| selHigh | input | 1 | Chip select, active high |
| wrN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output gate, active low |
| hiByteN | input | 1 | Upper lane select (bits 15..8), active low |
| loByteN | input | 1 | Lower lane select (bits 7..0), active low |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Read data, zero in undriven lanes |
| outValid | output | 2 | Per-lane drive flag; bit 1 upper, bit 0 lower |

## Verification
The embedded properties assume that every control input is sampled once per clock and held between edges. They also assume that a standby, a write or a gated-off output in one cycle is observed at the next edge, so every rule is phrased as a one-cycle implication. The bench follows this by changing all inputs in one place, a little after each rising edge, and never between edges. It sweeps every word of the default depth, first with writes and then with page-ordered reads. It recomputes the expected word from an address formula and from a shadow copy that it updates lane by lane on partial writes.

// File: rtl/paged_sram_pkg.sv
package paged_sram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;

  // Strobes from the control to the datapath, one bit per byte lane
  typedef struct packed {
    logic [LANES-1:0] wrLane;   // store this lane at the edge
    logic [LANES-1:0] outLane;  // drive this lane from the array at the edge
  } sramStrobe_t;
endpackage

// File: rtl/paged_sram_ctrl.sv
module paged_sram_ctrl
  import paged_sram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_BITS = 4,
  parameter int HIT_LAT   = 1,
  parameter int MISS_LAT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selLowN,
  input  logic              selHigh,
  input  logic              wrN,
  input  logic              oeN,
  input  logic              hiByteN,
  input  logic              loByteN,
  output sramStrobe_t       strobe
);
  localparam int PAGE_W = ADDR_W - PAGE_BITS;
  localparam int CNT_W  = $clog2(MISS_LAT + 1);
  localparam logic [CNT_W-1:0] HIT_CNT  = CNT_W'(HIT_LAT);
  localparam logic [CNT_W-1:0] MISS_CNT = CNT_W'(MISS_LAT);

  logic [LANES-1:0]  laneOn;
  logic              chipOn, selected, isWrite, isRead;
  logic [PAGE_W-1:0] curPage, hitPage;
  logic              hitValid, pageHit;
  logic              busy, sameReq, done;
  logic [ADDR_W-1:0] reqAddr;
  logic [CNT_W-1:0]  cnt, cntNext, need, needNext;

  // Mode decode
  assign chipOn   = !selLowN && selHigh;
  assign laneOn   = ~{hiByteN, loByteN};
  assign selected = chipOn && (|laneOn);
  assign isWrite  = selected && !wrN;
  assign isRead   = selected && wrN;

  // Page tracking
  assign curPage = addr[ADDR_W-1:PAGE_BITS];
  assign pageHit = hitValid && (curPage == hitPage);

  // Latency counting for a held read address
  assign sameReq  = busy && (addr == reqAddr);
  assign needNext = sameReq ? need : (pageHit ? HIT_CNT : MISS_CNT);
  assign cntNext  = sameReq ? ((cnt >= need) ? cnt : cnt + CNT_W'(1)) : CNT_W'(1);
  assign done     = isRead && (cntNext >= needNext);

  always_comb begin
    strobe.wrLane  = isWrite ? laneOn : '0;
    strobe.outLane = done ? (laneOn & {LANES{!oeN}}) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      reqAddr  <= '0;
      cnt      <= '0;
      need     <= MISS_CNT;
      hitValid <= 1'b0;
      hitPage  <= '0;
    end else if (!selected) begin
      busy     <= 1'b0;
      hitValid <= 1'b0;
    end else if (isWrite) begin
      busy <= 1'b0;
    end else begin
      busy    <= 1'b1;
      reqAddr <= addr;
      cnt     <= cntNext;
      need    <= needNext;
      if (done) begin
        hitValid <= 1'b1;
        hitPage  <= curPage;
      end
    end
  end

  // R7
  hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!selected) |=> !pageHit);
endmodule

// File: rtl/paged_sram_dp.sv
module paged_sram_dp
  import paged_sram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  sramStrobe_t             strobe,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic [LANES-1:0]        outValid
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] laneOut;
    logic              laneVld;

    always_ff @(posedge clk) begin
      if (strobe.wrLane[g]) bank[addr] <= dataIn[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        laneOut <= '0;
        laneVld <= 1'b0;
      end else if (strobe.outLane[g]) begin
        laneOut <= bank[addr];
        laneVld <= 1'b1;
      end else begin
        laneOut <= '0;
        laneVld <= 1'b0;
      end
    end

    assign dataOut[g*LANE_W +: LANE_W] = laneOut;
    assign outValid[g]                 = laneVld;
  end
endmodule

// File: rtl/paged_sram.sv
module paged_sram
  import paged_sram_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int PAGE_BITS = 4,
  parameter int HIT_LAT   = 1,
  parameter int MISS_LAT  = 3,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selLowN,
  input  logic              selHigh,
  input  logic              wrN,
  input  logic              oeN,
  input  logic              hiByteN,
  input  logic              loByteN,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic [1:0]        outValid
);
  sramStrobe_t strobe;

  paged_sram_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .selLowN(selLowN), .selHigh(selHigh),
    .wrN(wrN), .oeN(oeN), .hiByteN(hiByteN), .loByteN(loByteN), .strobe(strobe)
  );

  paged_sram_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dataIn(dataIn), .strobe(strobe),
    .dataOut(dataOut), .outValid(outValid)
  );

  // R1
  ce_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (selLowN || !selHigh) |=> (outValid == 2'b00));
  // R2
  lane_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hiByteN && loByteN) |=> (outValid == 2'b00));
  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrN) |=> (outValid == 2'b00));
  // R4
  lo_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loByteN |=> !outValid[0]);
  // R4
  hi_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiByteN |=> !outValid[1]);
  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oeN |=> (outValid == 2'b00));
endmodule

// File: tb/paged_sram_bench.sv
module paged_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1024;
  localparam int AW         = $clog2(DEPTH);
  localparam int PAGE_WORDS = 16;
  localparam int MISS       = 3;
  localparam int HIT        = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic selLowN = 1'b1, selHigh = 1'b0, wrN = 1'b1, oeN = 1'b1;
  logic hiByteN = 1'b1, loByteN = 1'b1;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic [1:0]  outValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] refMem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_sram u_paged_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .selLowN(selLowN), .selHigh(selHigh),
    .wrN(wrN), .oeN(oeN), .hiByteN(hiByteN), .loByteN(loByteN), .dataIn(dataIn),
    .dataOut(dataOut), .outValid(outValid)
  );

  function automatic logic [15:0] pat(int a);
    logic [31:0] v;
    v = (a * 40503) ^ 32'h5A5A;
    return v[15:0];
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(logic c1n, logic c2, logic w, logic o, logic hn, logic ln,
                       int a, logic [15:0] d);
    selLowN = c1n; selHigh = c2; wrN = w; oeN = o;
    hiByteN = hn; loByteN = ln; addr = AW'(a); dataIn = d;
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 16'h0);
  endtask

  task automatic check(string req, logic [1:0] expV, logic [15:0] expD);
    checks++;
    if (outValid !== expV || dataOut !== expD) begin
      errors++;
      $display("FAIL %s valid=%b data=%h expected valid=%b data=%h",
               req, outValid, dataOut, expV, expD);
    end
  endtask

  // Full-width read held at one address for lat edges
  task automatic readAt(int a, int lat, string req);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, a, 16'h0);
    for (int i = 1; i < lat; i++) begin
      step();
      check(req, 2'b00, 16'h0);
    end
    step();
    check(req, 2'b11, refMem[a]);
  endtask

  initial begin
    idle();
    step();
    check("R10", 2'b00, 16'h0);
    step();
    rst_n = 1'b1;
    step();
    check("R10", 2'b00, 16'h0);

    // R3: fill every word, output gate toggled to show it is ignored
    for (int a = 0; a < DEPTH; a++) begin
      drive(1'b0, 1'b1, 1'b0, a[0], 1'b0, 1'b0, a, pat(a));
      refMem[a] = pat(a);
      step();
      check("R3", 2'b00, 16'h0);
    end

    // R5 / R6: page-ordered sweep
    for (int p = 0; p < DEPTH / PAGE_WORDS; p++) begin
      readAt(p * PAGE_WORDS, MISS, "R5");
      for (int w = 1; w < PAGE_WORDS; w++) readAt(p * PAGE_WORDS + w, HIT, "R6");
    end

    // R1 / R2: writes while in standby change nothing
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5, 16'hDEAD);
    step(); check("R1", 2'b00, 16'h0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5, 16'hBEEF);
    step(); check("R1", 2'b00, 16'h0);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6, 16'hF00D);
    step(); check("R2", 2'b00, 16'h0);
    readAt(5, MISS, "R1");
    readAt(6, HIT, "R2");

    // R7: each standby flavour clears the page hit
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7, 16'h0);
    step(); check("R1", 2'b00, 16'h0);
    readAt(7, MISS, "R7");
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8, 16'h0);
    step(); check("R2", 2'b00, 16'h0);
    readAt(8, MISS, "R7");

    // R4: single-lane reads on a hit page
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9, 16'h0);
    step(); check("R4", 2'b01, {8'h00, refMem[9][7:0]});
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10, 16'h0);
    step(); check("R4", 2'b10, {refMem[10][15:8], 8'h00});

    // R3: single-lane writes keep the other lane
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 20, 16'hABCD);
    refMem[20][7:0] = 8'hCD;
    step(); check("R3", 2'b00, 16'h0);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 21, 16'h1234);
    refMem[21][15:8] = 8'h12;
    step(); check("R3", 2'b00, 16'h0);
    readAt(20, MISS, "R3");
    readAt(21, HIT, "R3");

    // R6: a write between reads keeps the page hit
    readAt(22, HIT, "R6");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 23, 16'h7777);
    refMem[23] = 16'h7777;
    step(); check("R6", 2'b00, 16'h0);
    readAt(23, HIT, "R6");

    // R8: address change aborts and restarts the count
    idle(); step();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 40, 16'h0);
    step(); check("R8", 2'b00, 16'h0);
    step(); check("R8", 2'b00, 16'h0);
    readAt(100, MISS, "R8");
    // R8: deselect aborts
    idle(); step();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 200, 16'h0);
    step(); check("R8", 2'b00, 16'h0);
    step(); check("R8", 2'b00, 16'h0);
    idle(); step(); check("R8", 2'b00, 16'h0);
    readAt(200, MISS, "R8");

    // R9: gated output while the access counts
    idle(); step();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 300, 16'h0);
    for (int i = 0; i < 4; i++) begin
      step(); check("R9", 2'b00, 16'h0);
    end
    oeN = 1'b0;
    step(); check("R9", 2'b11, refMem[300]);
    oeN = 1'b1;
    step(); check("R9", 2'b00, 16'h0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule